// File: doc/BRIEF.md
# Two-Way Interprocessor Mailbox

This peripheral joins two processors, called side A and side B, so that either one can post a message to the other. A message is a command word plus a data word. There are `NCH` channels in each direction. Each side has its own register port, and that port carries a write strobe, a read strobe, a byte address and data. The registers form two banks. The A-to-B bank sits at the low addresses. The B-to-A bank follows it directly. Both sides see the same address map.

To send, the processor writes the command word and then the data word of a channel in its outgoing bank. The data write raises that channel's pending bit. The sender treats a raised pending bit as "busy", and the message counts as delivered once the bit reads zero. The receiving processor enables the interrupts it cares about. It reads the two words and then acknowledges by writing a 1 to the channel's bit in the pending register. Each channel drives its own level interrupt towards the receiver.

Top module: `ipc_mailbox`

## Requirements
- R1: After the synchronous active-high reset, every register reads zero and all interrupt outputs are low.
- R2: Each bank is 8+8·NCH bytes long. The A-to-B bank starts at 0x00 and the B-to-A bank follows it (0x28 for NCH=4). Within a bank, offset 0x00 is interrupt enable, 0x04 is pending, channel x's command word is at 0x08+8·x and its data word is at 0x0C+8·x. Both sides can read every register. Read data appears on the cycle after the read strobe, reflects the state before any write in the same cycle, and is zero on any cycle after which no read was requested.
- R3: A data-register write by the sending side sets that channel's pending bit. A command-register write alone leaves pending unchanged. Both words are stored and read back.
- R4: The receiving side clears pending bits by writing the pending register: each 1 clears that bit, and each 0 leaves its bit unchanged.
- R5: The interrupt of channel x in a bank is high exactly when its pending bit and its enable bit are both set. It stays high until one of them is cleared.
- R6: The receiving side writes the enable register as a whole. Bit x enables channel x. Enable bits read back individually, and bits at or above NCH read as zero.
- R7: In each bank, only the sender (A for the A-to-B bank, B for B-to-A) writes command and data registers, and only the receiver writes enable and pending. Writes from the other side leave all registers unchanged.
- R8: A data write to a channel that is still pending overwrites the stored words, and the pending bit stays set.
- R9: If a data write and an acknowledge of the same channel happen in the same cycle, the channel ends up pending.
- R10: Reads at unaligned addresses or beyond the second bank return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_addr | input | AW | Side A byte address |
| a_wdata | input | DW | Side A write data |
| a_rdata | output | DW | Side A read data, one cycle after a_rd |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_addr | input | AW | Side B byte address |
| b_wdata | input | DW | Side B write data |
| b_rdata | output | DW | Side B read data, one cycle after b_rd |
| irq_to_b | output | NCH | Per-channel interrupts of the A-to-B bank |
| irq_to_a | output | NCH | Per-channel interrupts of the B-to-A bank |

## Verification
The interrupt properties assume that an interrupt changes only as the result of a write from the side allowed to cause the change. They also assume the read-data property sees read strobes held low while reset is asserted. The bench drives all inputs shortly after the rising edge and keeps the strobes low during reset. Its directed phases always issue writes through the two bus ports, never any other way. The random phase mixes aligned, unaligned and out-of-range addresses on both sides at once, so wrong-side writes and same-cycle collisions are exercised as well.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [2:0] {
    RK_NONE,
    RK_ENABLE,
    RK_PENDING,
    RK_CMD,
    RK_DATA
  } reg_kind_e;

  // bytes per bank: enable and pending words, then a word pair per channel
  function automatic int bank_span(input int nch);
    return 8 + 8 * nch;
  endfunction
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NCH  = 4,
  parameter int BASE = 0,
  parameter int CW   = 2
) (
  input  logic [AW-1:0] addr,
  output reg_kind_e     kind,
  output logic [CW-1:0] idx
);
  localparam int SPAN = bank_span(NCH);

  int off;

  always_comb begin
    off  = int'(addr) - BASE;
    kind = RK_NONE;
    idx  = '0;
    if (addr[1:0] == 2'b00 && off >= 0 && off < SPAN) begin
      if (off == 0) begin
        kind = RK_ENABLE;
      end else if (off == 4) begin
        kind = RK_PENDING;
      end else begin
        idx  = CW'((off - 8) / 8);
        kind = off[2] ? RK_DATA : RK_CMD;
      end
    end
  end
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int CW  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     snd_cmd_we,
  input  logic                     snd_dat_we,
  input  logic [CW-1:0]            snd_idx,
  input  logic [DW-1:0]            snd_wdata,
  input  logic                     rcv_en_we,
  input  logic                     rcv_clr_we,
  input  logic [NCH-1:0]           rcv_wdata,
  output logic [NCH-1:0][DW-1:0]   cmd_q,
  output logic [NCH-1:0][DW-1:0]   dat_q,
  output logic [NCH-1:0]           pend_q,
  output logic [NCH-1:0]           en_q,
  output logic [NCH-1:0]           irq_q
);
  logic [NCH-1:0] en_nxt;
  logic [NCH-1:0] pend_nxt;

  assign en_nxt = rcv_en_we ? rcv_wdata : en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_nxt;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic sel, set_c, clr_c;
    assign sel   = (snd_idx == CW'(c));
    assign set_c = snd_dat_we & sel;
    assign clr_c = rcv_clr_we & rcv_wdata[c];
    // a new message wins over a simultaneous acknowledge
    assign pend_nxt[c] = set_c | (pend_q[c] & ~clr_c);

    always_ff @(posedge clk) begin
      if (rst) begin
        cmd_q[c]  <= '0;
        dat_q[c]  <= '0;
        pend_q[c] <= 1'b0;
        irq_q[c]  <= 1'b0;
      end else begin
        if (snd_cmd_we && sel) cmd_q[c] <= snd_wdata;
        if (set_c)             dat_q[c] <= snd_wdata;
        pend_q[c] <= pend_nxt[c];
        irq_q[c]  <= pend_nxt[c] & en_nxt[c];
      end
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbox_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           a_wr,
  input  logic           a_rd,
  input  logic [AW-1:0]  a_addr,
  input  logic [DW-1:0]  a_wdata,
  output logic [DW-1:0]  a_rdata,
  input  logic           b_wr,
  input  logic           b_rd,
  input  logic [AW-1:0]  b_addr,
  input  logic [DW-1:0]  b_wdata,
  output logic [DW-1:0]  b_rdata,
  output logic [NCH-1:0] irq_to_b,
  output logic [NCH-1:0] irq_to_a
);
  localparam int SPAN = bank_span(NCH);
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int NP   = 2;  // ports A=0, B=1; bank g is sent by port g

  logic [NP-1:0]         p_wr, p_rd;
  logic [AW-1:0]         p_addr  [NP];
  logic [DW-1:0]         p_wdata [NP];
  logic [DW-1:0]         rdata_q [NP];
  logic [DW-1:0]         rdata_nxt [NP];

  reg_kind_e             kind [NP][NP];  // [port][bank]
  logic [CW-1:0]         idx  [NP][NP];

  logic [NCH-1:0][DW-1:0] bk_cmd  [NP];
  logic [NCH-1:0][DW-1:0] bk_dat  [NP];
  logic [NCH-1:0]         bk_pend [NP];
  logic [NCH-1:0]         bk_en   [NP];
  logic [NCH-1:0]         bk_irq  [NP];

  assign p_wr       = {b_wr, a_wr};
  assign p_rd       = {b_rd, a_rd};
  assign p_addr[0]  = a_addr;
  assign p_addr[1]  = b_addr;
  assign p_wdata[0] = a_wdata;
  assign p_wdata[1] = b_wdata;

  for (genvar p = 0; p < NP; p++) begin : g_port
    for (genvar g = 0; g < NP; g++) begin : g_dec
      mbox_decode #(
        .AW(AW), .NCH(NCH), .BASE(g * SPAN), .CW(CW)
      ) u_dec (
        .addr (p_addr[p]),
        .kind (kind[p][g]),
        .idx  (idx[p][g])
      );
    end

    always_comb begin
      rdata_nxt[p] = '0;
      for (int g = 0; g < NP; g++) begin
        case (kind[p][g])
          RK_ENABLE:  rdata_nxt[p] = rdata_nxt[p] | DW'(bk_en[g]);
          RK_PENDING: rdata_nxt[p] = rdata_nxt[p] | DW'(bk_pend[g]);
          RK_CMD:     rdata_nxt[p] = rdata_nxt[p] | bk_cmd[g][idx[p][g]];
          RK_DATA:    rdata_nxt[p] = rdata_nxt[p] | bk_dat[g][idx[p][g]];
          default:    ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst)           rdata_q[p] <= '0;
      else if (p_rd[p])  rdata_q[p] <= rdata_nxt[p];
      else               rdata_q[p] <= '0;
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_bank
    localparam int S = g;
    localparam int R = 1 - g;
    mbox_bank #(.NCH(NCH), .DW(DW), .CW(CW)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .snd_cmd_we (p_wr[S] && kind[S][g] == RK_CMD),
      .snd_dat_we (p_wr[S] && kind[S][g] == RK_DATA),
      .snd_idx    (idx[S][g]),
      .snd_wdata  (p_wdata[S]),
      .rcv_en_we  (p_wr[R] && kind[R][g] == RK_ENABLE),
      .rcv_clr_we (p_wr[R] && kind[R][g] == RK_PENDING),
      .rcv_wdata  (p_wdata[R][NCH-1:0]),
      .cmd_q      (bk_cmd[g]),
      .dat_q      (bk_dat[g]),
      .pend_q     (bk_pend[g]),
      .en_q       (bk_en[g]),
      .irq_q      (bk_irq[g])
    );
  end

  assign a_rdata  = rdata_q[0];
  assign b_rdata  = rdata_q[1];
  assign irq_to_b = bk_irq[0];
  assign irq_to_a = bk_irq[1];
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           a_wr,
  input logic           a_rd,
  input logic [AW-1:0]  a_addr,
  input logic [DW-1:0]  a_rdata,
  input logic           b_wr,
  input logic           b_rd,
  input logic [AW-1:0]  b_addr,
  input logic [DW-1:0]  b_rdata,
  input logic [NCH-1:0] irq_to_b,
  input logic [NCH-1:0] irq_to_a
);
  localparam int SPAN = 8 + 8 * NCH;

  // R1
  irq_reset_low_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_to_b == '0 && irq_to_a == '0));

  // R2
  a_rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) || !$past(a_rd)) |-> a_rdata == '0);

  // R2
  b_rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) || !$past(b_rd)) |-> b_rdata == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] D0 = AW'(12 + 8 * c);
    localparam logic [AW-1:0] D1 = AW'(SPAN + 12 + 8 * c);
    localparam logic [AW-1:0] E0 = AW'(0);
    localparam logic [AW-1:0] P0 = AW'(4);
    localparam logic [AW-1:0] E1 = AW'(SPAN);
    localparam logic [AW-1:0] P1 = AW'(SPAN + 4);

    // R3
    irq_b_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_to_b[c]) |->
        (($past(a_wr) && $past(a_addr) == D0) || ($past(b_wr) && $past(b_addr) == E0)));

    // R3
    irq_a_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_to_a[c]) |->
        (($past(b_wr) && $past(b_addr) == D1) || ($past(a_wr) && $past(a_addr) == E1)));

    // R4 R7
    irq_b_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(irq_to_b[c]) |->
        ($past(b_wr) && ($past(b_addr) == E0 || $past(b_addr) == P0)));

    // R4 R7
    irq_a_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(irq_to_a[c]) |->
        ($past(a_wr) && ($past(a_addr) == E1 || $past(a_addr) == P1)));
  end
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_wr     (a_wr),
  .a_rd     (a_rd),
  .a_addr   (a_addr),
  .a_rdata  (a_rdata),
  .b_wr     (b_wr),
  .b_rd     (b_rd),
  .b_addr   (b_addr),
  .b_rdata  (b_rdata),
  .irq_to_b (irq_to_b),
  .irq_to_a (irq_to_a)
);

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  localparam int NCH  = 4;
  localparam int DW   = 32;
  localparam int AW   = 8;
  localparam int SPAN = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  wire  [DW-1:0] a_rdata, b_rdata;
  wire [NCH-1:0] irq_to_b, irq_to_a;

  ipc_mailbox #(.NCH(NCH), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq_to_b(irq_to_b), .irq_to_a(irq_to_a)
  );

  // behavioural reference: bank 0 is A-to-B, bank 1 is B-to-A
  logic [NCH-1:0] m_en [2];
  logic [NCH-1:0] m_pend [2];
  logic [DW-1:0]  m_cmd [2][NCH];
  logic [DW-1:0]  m_dat [2][NCH];
  logic [DW-1:0]  e_rdata [2] = '{default: '0};
  logic [NCH-1:0] e_irq [2]   = '{default: '0};

  int    vectors = 0;
  int    miscompares = 0;
  string tag = "R1";
  bit    finished = 0;

  // kind: 0 none, 1 enable, 2 pending, 3 command, 4 data
  function automatic void mdec(input int addr, output int bank, output int kind, output int ch);
    int off;
    bank = addr / SPAN;
    off  = addr % SPAN;
    kind = 0;
    ch   = 0;
    if (addr % 4 != 0 || bank > 1) return;
    if (off == 0)      kind = 1;
    else if (off == 4) kind = 2;
    else begin
      ch   = (off - 8) / 8;
      kind = (off % 8 == 0) ? 3 : 4;
    end
  endfunction

  function automatic logic [DW-1:0] mread(input int addr);
    int bk, kd, ch;
    mdec(addr, bk, kd, ch);
    case (kd)
      1: return {{(DW-NCH){1'b0}}, m_en[bk]};
      2: return {{(DW-NCH){1'b0}}, m_pend[bk]};
      3: return m_cmd[bk][ch];
      4: return m_dat[bk][ch];
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    logic           pw [2];
    int             pa [2];
    logic [DW-1:0]  pd [2];
    logic [NCH-1:0] setm, clrm;
    int bk, kd, ch, r;
    if (rst) begin
      for (int g = 0; g < 2; g++) begin
        m_en[g] = '0; m_pend[g] = '0; e_rdata[g] = '0; e_irq[g] = '0;
        for (int c = 0; c < NCH; c++) begin m_cmd[g][c] = '0; m_dat[g][c] = '0; end
      end
    end else begin
      pw[0] = a_wr; pa[0] = int'(a_addr); pd[0] = a_wdata;
      pw[1] = b_wr; pa[1] = int'(b_addr); pd[1] = b_wdata;
      e_rdata[0] = a_rd ? mread(int'(a_addr)) : '0;
      e_rdata[1] = b_rd ? mread(int'(b_addr)) : '0;
      for (int g = 0; g < 2; g++) begin
        r = 1 - g;
        setm = '0;
        clrm = '0;
        if (pw[g]) begin
          mdec(pa[g], bk, kd, ch);
          if (bk == g && kd == 3) m_cmd[g][ch] = pd[g];
          if (bk == g && kd == 4) begin m_dat[g][ch] = pd[g]; setm[ch] = 1'b1; end
        end
        if (pw[r]) begin
          mdec(pa[r], bk, kd, ch);
          if (bk == g && kd == 1) m_en[g] = pd[r][NCH-1:0];
          if (bk == g && kd == 2) clrm = pd[r][NCH-1:0];
        end
        m_pend[g] = (m_pend[g] & ~clrm) | setm;
        e_irq[g]  = m_pend[g] & m_en[g];
      end
    end
  end

  task automatic check(input string nm, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check("a_rdata", a_rdata, e_rdata[0]);
      check("b_rdata", b_rdata, e_rdata[1]);
      check("irq_to_b", DW'(irq_to_b), DW'(e_irq[0]));
      check("irq_to_a", DW'(irq_to_a), DW'(e_irq[1]));
    end
  end

  task automatic drive(input logic aw, input logic ar, input int aa, input logic [DW-1:0] ad,
                       input logic bw, input logic br, input int ba, input logic [DW-1:0] bd);
    @(posedge clk);
    #2;
    a_wr = aw; a_rd = ar; a_addr = AW'(aa); a_wdata = ad;
    b_wr = bw; b_rd = br; b_addr = AW'(ba); b_wdata = bd;
  endtask

  task automatic idle();
    drive(0, 0, 0, '0, 0, 0, 0, '0);
  endtask

  task automatic read_both(input int addr);
    drive(0, 1, addr, '0, 0, 1, addr, '0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run still active, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    tag = "R1";
    for (int i = 0; i < 20; i++) drive(0, 1, i * 4, '0, 0, 1, (i * 4 + SPAN) % 80, '0);

    tag = "R3";
    drive(1, 0, 8 + 16, 32'hC0DE_0002, 0, 1, 4, '0);
    read_both(4);
    for (int c = 0; c < NCH; c++) begin
      drive(1, 0, 8 + 8 * c, 32'hA000_0000 + c, 0, 0, 0, '0);
      drive(1, 0, 12 + 8 * c, 32'hD000_0010 + c, 0, 1, 4, '0);
    end
    read_both(4);

    tag = "R2";
    for (int i = 0; i < 10; i++) read_both(i * 4);

    tag = "R6";
    drive(0, 0, 0, '0, 1, 0, 0, 32'hFFFF_FFFF);
    read_both(0);
    drive(0, 0, 0, '0, 1, 0, 0, 32'h0000_0005);
    read_both(0);

    tag = "R4";
    drive(0, 0, 0, '0, 1, 0, 4, 32'h0000_0002);
    read_both(4);
    drive(0, 0, 0, '0, 1, 0, 4, 32'h0000_0000);
    read_both(4);
    drive(0, 0, 0, '0, 1, 0, 4, 32'h0000_0004);
    read_both(4);

    tag = "R5";
    drive(0, 0, 0, '0, 1, 0, 0, 32'h0000_000F);
    idle();
    drive(0, 0, 0, '0, 1, 0, 4, 32'h0000_0001);
    idle();
    drive(0, 0, 0, '0, 1, 0, 0, 32'h0000_0000);
    idle();

    tag = "R7";
    drive(0, 0, 0, '0, 1, 0, 12 + 24, 32'hBAD0_0003);
    drive(1, 0, 4, 32'h0000_000F, 0, 0, 0, '0);
    drive(1, 0, 0, 32'h0000_000F, 0, 0, 0, '0);
    drive(1, 0, SPAN + 12, 32'hBAD0_1000, 0, 0, 0, '0);
    drive(0, 0, 0, '0, 1, 0, SPAN + 4, 32'h0000_000F);
    for (int i = 0; i < 20; i++) read_both(i * 4);

    tag = "R8";
    drive(1, 0, 8 + 24, 32'hC0DE_0033, 0, 0, 0, '0);
    drive(1, 0, 12 + 24, 32'hDA7A_0033, 0, 1, 4, '0);
    read_both(12 + 24);
    read_both(4);

    tag = "R9";
    drive(1, 0, 12 + 8, 32'hDA7A_0011, 1, 0, 4, 32'h0000_0002);
    read_both(4);
    drive(0, 1, SPAN + 4, '0, 1, 0, SPAN + 12 + 16, 32'h1234_5678);
    drive(0, 1, SPAN + 4, '0, 1, 0, SPAN, 32'h0000_0004);
    drive(1, 0, SPAN + 4, 32'h0000_0004, 1, 0, SPAN + 12 + 16, 32'h8765_4321);
    read_both(SPAN + 4);

    tag = "R10";
    read_both(80);
    read_both(2);
    read_both(252);
    drive(0, 0, 0, '0, 1, 0, 5, 32'h0000_000F);
    drive(1, 0, 13, 32'hFFFF_FFFF, 1, 0, 84, 32'hFFFF_FFFF);
    read_both(4);
    read_both(SPAN + 4);

    tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      int aa, ba;
      aa = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 21)) * 4;
      ba = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 21)) * 4;
      drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), aa, $urandom,
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ba, $urandom);
    end
    idle();
    idle();
    @(posedge clk);
    finish_run();
  end
endmodule